// File: doc/BRIEF.md
# Flash Single-Word Program Command Controller

This block is the device-side command decoder and write state machine for single-word programming of a NOR-style flash array model. The host issues bus write cycles. A write of 40h or 10h arms a program. The next write supplies the target address and data. After that write the block runs an internally timed program phase and then a verify phase on a behavioural memory array. That array starts fully erased, with every bit at one.

A status register reports readiness and sticky error causes. Any read returns it while the block is in status mode. Two other reads give fixed placeholder values: one for the device identifier and one for the query table. Each block of the array has a lock input. A supply-valid input gates every program: a missing supply or a locked target aborts the operation before the array is touched.

Top module: `fwp_cmd_ctrl`

## Requirements
- R1: After a write of 40h or 10h and a following data write, the word at the given address becomes the old word ANDed with the data. Every other address is unchanged.
- R2: After a setup write, and after any 70h write, a read at any address returns the status register in bits 7:0 with bits 15:8 zero. The block stays in status mode until another mode-changing command is written.
- R3: Status bit 7 reads 0 for exactly PROG_CYC+1 cycles, counted from the edge that accepts the data write. It then reads 1.
- R4: If supply_ok_i is low at the data write, status bits 4 and 3 are set. The array is unchanged and bit 7 never drops. The supply check takes priority over the lock check, so bit 1 is not set in this case.
- R5: If the target block's lock bit is set (block index = address bits [ADDR_W-1 -: log2(NUM_BLK)]), status bits 4 and 1 are set. The array is unchanged and bit 7 never drops.
- R6: Programming never changes a 0 bit to 1.
- R7: While busy, only FFh, 70h, 90h and 98h are acted on. 40h, 10h and 50h are ignored. A read in array mode while busy returns 16'hBAD0.
- R8: When ready, a write of 50h clears status bits 4, 3 and 1. The read mode is left as it was.
- R9: Error bits are sticky: a later successful program does not clear them.
- R10: FFh selects array mode, in which a read returns the addressed word. 90h makes every read return 16'h00E1. 98h makes every read return 16'h0051.
- R11: After reset the block is in array mode, every word reads FFFFh, and the status register is 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Word address for reads and writes |
| wdata_i | input | DATA_W | Write data; command code in bits 7:0 |
| rdata_o | output | DATA_W | Read data for the current mode and address |
| supply_ok_i | input | 1 | Programming supply is within limits |
| lock_i | input | NUM_BLK | Per-block lock bits |

## Verification
The hardest case to reach is a command arriving while the program timer is running. The bench reaches it by issuing 50h and 40h in the middle of a busy period, after errors have already been logged. It then shows at the ports that the errors survive. It also shows that the stray 40h did not arm a setup: a later FFh still selects array mode instead of being taken as program data. A lock-plus-supply-fault program checks that the supply fault takes priority.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam logic [7:0] CMD_SETUP_A = 8'h40;
  localparam logic [7:0] CMD_SETUP_B = 8'h10;
  localparam logic [7:0] CMD_CLR_SR  = 8'h50;
  localparam logic [7:0] CMD_RD_ARR  = 8'hFF;
  localparam logic [7:0] CMD_RD_SR   = 8'h70;
  localparam logic [7:0] CMD_RD_ID   = 8'h90;
  localparam logic [7:0] CMD_RD_QRY  = 8'h98;

  localparam logic [15:0] ID_WORD   = 16'h00E1;
  localparam logic [15:0] QRY_WORD  = 16'h0051;
  localparam logic [15:0] BUSY_WORD = 16'hBAD0;

  typedef enum logic [1:0] {MD_ARRAY, MD_STATUS, MD_IDENT, MD_QUERY} rd_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PROG, ST_VERIFY} wsm_state_e;

  function automatic logic is_rd_cmd(input logic [7:0] c);
    return c == CMD_RD_ARR || c == CMD_RD_SR || c == CMD_RD_ID || c == CMD_RD_QRY;
  endfunction

  function automatic rd_mode_e rd_mode_of(input logic [7:0] c, input rd_mode_e cur);
    case (c)
      CMD_RD_ARR: return MD_ARRAY;
      CMD_RD_SR:  return MD_STATUS;
      CMD_RD_ID:  return MD_IDENT;
      CMD_RD_QRY: return MD_QUERY;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/fwp_array.sv
module fwp_array #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem[g] <= '1;
      else if (commit_i && waddr_i == ADDR_W'(g))      mem[g] <= mem[g] & wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

  // R6: a stored word seen through port b never gains a one
  a_r6_no_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(raddr_b_i) |-> ((rdata_b_o & ~$past(rdata_b_o)) == '0));
endmodule

// File: rtl/fwp_status.sv
module fwp_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       clr_i,
  input  logic       err_vpp_i,
  input  logic       err_lock_i,
  input  logic       err_vfy_i,
  output logic [7:0] sr_o
);
  logic e_prog_q, e_vpp_q, e_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_prog_q <= 1'b0;
      e_vpp_q  <= 1'b0;
      e_lock_q <= 1'b0;
    end else if (clr_i) begin
      e_prog_q <= 1'b0;
      e_vpp_q  <= 1'b0;
      e_lock_q <= 1'b0;
    end else begin
      e_prog_q <= e_prog_q | err_vpp_i | err_lock_i | err_vfy_i;
      e_vpp_q  <= e_vpp_q  | err_vpp_i;
      e_lock_q <= e_lock_q | err_lock_i;
    end
  end

  assign sr_o = {!busy_i, 2'b00, e_prog_q, e_vpp_q, 1'b0, e_lock_q, 1'b0};

  a_r4_vpp_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vpp_i |=> (sr_o[4] && sr_o[3]));
  a_r9_sticky_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[1] && !clr_i) |=> sr_o[1]);
  a_r7_no_clear_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !busy_i);
endmodule

// File: rtl/fwp_wsm.sv
module fwp_wsm
  import fwp_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 8,
  localparam int CNT_W   = $clog2(PROG_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              supply_ok_i,
  input  logic              lock_hit_i,
  input  logic [DATA_W-1:0] rd_b_i,
  output rd_mode_e          mode_o,
  output logic              busy_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic              clr_o,
  output logic              err_vpp_o,
  output logic              err_lock_o,
  output logic              err_vfy_o
);
  wsm_state_e        state_q;
  rd_mode_e          mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] exp_q;
  logic [7:0]        cmd;

  assign cmd        = wdata_i[7:0];
  assign busy_o     = state_q == ST_PROG || state_q == ST_VERIFY;
  assign commit_o   = state_q == ST_PROG && cnt_q == CNT_W'(PROG_CYC - 1);
  assign clr_o      = state_q == ST_IDLE && we_i && cmd == CMD_CLR_SR;
  assign err_vpp_o  = state_q == ST_SETUP && we_i && !supply_ok_i;
  assign err_lock_o = state_q == ST_SETUP && we_i && supply_ok_i && lock_hit_i;
  assign err_vfy_o  = state_q == ST_VERIFY && rd_b_i != exp_q;
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_ARRAY;
      cnt_q   <= '0;
      paddr_o <= '0;
      pdata_o <= '0;
      exp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (we_i) begin
          if (cmd == CMD_SETUP_A || cmd == CMD_SETUP_B) begin
            state_q <= ST_SETUP;
            mode_q  <= MD_STATUS;
          end else begin
            mode_q <= rd_mode_of(cmd, mode_q);
          end
        end
        ST_SETUP: if (we_i) begin
          mode_q <= MD_STATUS;
          if (!supply_ok_i || lock_hit_i) begin
            state_q <= ST_IDLE;
          end else begin
            paddr_o <= addr_i;
            pdata_o <= wdata_i;
            cnt_q   <= '0;
            state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (we_i && is_rd_cmd(cmd)) mode_q <= rd_mode_of(cmd, mode_q);
          cnt_q <= cnt_q + 1'b1;
          if (commit_o) begin
            exp_q   <= rd_b_i & pdata_o;
            state_q <= ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (we_i && is_rd_cmd(cmd)) mode_q <= rd_mode_of(cmd, mode_q);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_ready_after_verify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(state_q) == ST_VERIFY);
  a_r5_lock_no_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lock_o |=> !busy_o);
  a_r4_vpp_no_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vpp_o |=> (!busy_o && !commit_o));
  a_r7_setup_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> state_q != ST_SETUP);
endmodule

// File: rtl/fwp_cmd_ctrl.sv
module fwp_cmd_ctrl
  import fwp_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int NUM_BLK  = 4,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 8,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              supply_ok_i,
  input  logic [NUM_BLK-1:0] lock_i
);
  rd_mode_e          mode;
  logic              busy, commit, clr, e_vpp, e_lock, e_vfy, lock_hit;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata, rd_a, rd_b;
  logic [7:0]        sr;
  logic [BLK_W-1:0]  blk;

  if (NUM_BLK > 1) begin : g_blk
    assign blk = addr_i[ADDR_W-1 -: BLK_W];
  end else begin : g_one
    assign blk = '0;
  end
  assign lock_hit = lock_i[blk];

  fwp_wsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) wsm_i (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .supply_ok_i,
    .lock_hit_i(lock_hit), .rd_b_i(rd_b), .mode_o(mode), .busy_o(busy),
    .commit_o(commit), .paddr_o(paddr), .pdata_o(pdata), .clr_o(clr),
    .err_vpp_o(e_vpp), .err_lock_o(e_lock), .err_vfy_o(e_vfy)
  );

  fwp_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) array_i (
    .clk_i, .rst_ni, .commit_i(commit), .waddr_i(paddr), .wdata_i(pdata),
    .raddr_a_i(addr_i), .rdata_a_o(rd_a), .raddr_b_i(paddr), .rdata_b_o(rd_b)
  );

  fwp_status status_i (
    .clk_i, .rst_ni, .busy_i(busy), .clr_i(clr), .err_vpp_i(e_vpp),
    .err_lock_i(e_lock), .err_vfy_i(e_vfy), .sr_o(sr)
  );

  always_comb begin
    unique case (mode)
      MD_ARRAY:  rdata_o = busy ? DATA_W'(BUSY_WORD) : rd_a;
      MD_STATUS: rdata_o = DATA_W'(sr);
      MD_IDENT:  rdata_o = DATA_W'(ID_WORD);
      default:   rdata_o = DATA_W'(QRY_WORD);
    endcase
  end

  a_r2_status_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_STATUS) |-> rdata_o[DATA_W-1:8] == '0);
endmodule

// File: tb/fwp_cmd_ctrl_tb_top.sv
module fwp_cmd_ctrl_tb_top;
  localparam int PROG_CYC = 8;
  logic        clk = 1'b0, rst_ni = 1'b0, we = 1'b0, sok = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  lock = '0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  fwp_cmd_ctrl #(.PROG_CYC(PROG_CYC)) dut_i (
    .clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .supply_ok_i(sok), .lock_i(lock)
  );

  // {addr, data, expected word after program}
  localparam logic [37:0] VEC [6] = '{
    {6'd3,  16'h1234, 16'h1234}, {6'd3,  16'hFF0F, 16'h1204},
    {6'd20, 16'h0000, 16'h0000}, {6'd63, 16'hA5A5, 16'hA5A5},
    {6'd63, 16'hFFFF, 16'hA5A5}, {6'd40, 16'h8001, 16'h8001}};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic logic [15:0] rd_at(input logic [5:0] a);
    addr = a;
    return rdata;
  endfunction

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic busy_len(output int n);
    logic [15:0] d;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(6'd9, d);
      if (d[7]) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(6'd0, d);  chk("R11 array erased", d, 16'hFFFF);
    rd(6'd63, d); chk("R11 array erased top", d, 16'hFFFF);
    wr(6'd0, 16'h0070);
    rd(6'd5, d);  chk("R11 status after reset", d, 16'h0080);
    // R10 placeholder reads
    wr(6'd0, 16'h0090); rd(6'd7, d); chk("R10 ident", d, 16'h00E1);
    wr(6'd0, 16'h0098); rd(6'd7, d); chk("R10 query", d, 16'h0051);

    // R1 R2 R3 R6 vector walk
    for (int i = 0; i < 6; i++) begin
      wr(6'd0, (i % 2 == 0) ? 16'h0040 : 16'h0010);
      wr(VEC[i][37:32], VEC[i][31:16]);
      busy_len(n);
      chk("R3 busy length", 16'(n), 16'(PROG_CYC + 1));
      rd(6'd33, d); chk("R2 status any addr", d, 16'h0080);
      wr(6'd0, 16'h00FF);
      rd(VEC[i][37:32], d); chk("R1 R6 programmed word", d, VEC[i][15:0]);
    end
    rd(6'd4, d); chk("R1 neighbour unchanged", d, 16'hFFFF);

    // R4 supply fault
    sok = 1'b0;
    wr(6'd0, 16'h0040); wr(6'd5, 16'h0000);
    rd(6'd0, d); chk("R4 supply fault status", d, 16'h0098);
    sok = 1'b1;
    wr(6'd0, 16'h00FF); rd(6'd5, d); chk("R4 array unchanged", d, 16'hFFFF);
    wr(6'd0, 16'h0050); wr(6'd0, 16'h0070);
    rd(6'd0, d); chk("R8 clear after supply fault", d, 16'h0080);

    // R4 priority over lock
    sok = 1'b0; lock = 4'b0001;
    wr(6'd0, 16'h0010); wr(6'd2, 16'h0000);
    rd(6'd0, d); chk("R4 supply over lock", d, 16'h0098);
    sok = 1'b1; lock = '0;
    wr(6'd0, 16'h0050);
    rd(6'd0, d); chk("R8 mode kept after clear", d, 16'h0080);

    // R5 locked block
    lock = 4'b0010;
    wr(6'd0, 16'h0040); wr(6'd17, 16'h0000);
    rd(6'd0, d); chk("R5 lock fault status", d, 16'h0092);
    wr(6'd0, 16'h00FF); rd(6'd17, d); chk("R5 array unchanged", d, 16'hFFFF);
    lock = '0;

    // R9 sticky across success
    wr(6'd0, 16'h0040); wr(6'd18, 16'h00FF);
    busy_len(n);
    rd(6'd0, d); chk("R9 error sticky", d, 16'h0092);

    // R7 commands during busy
    wr(6'd0, 16'h0040); wr(6'd19, 16'h0F0F);
    wr(6'd0, 16'h0050);
    wr(6'd0, 16'h0040);
    wr(6'd0, 16'h00FF);
    rd(6'd19, d); chk("R7 busy array pattern", d, 16'hBAD0);
    wr(6'd0, 16'h0070);
    busy_len(n);
    rd(6'd0, d); chk("R7 clear ignored busy", d, 16'h0092);
    wr(6'd0, 16'h00FF);
    rd(6'd19, d); chk("R7 setup ignored busy", d, 16'h0F0F);
    wr(6'd0, 16'h0050); wr(6'd0, 16'h0070);
    rd(6'd0, d); chk("R8 clear when ready", d, 16'h0080);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule